// File: doc/BRIEF.md
# CAN Controller Mailbox FIFO Window

This block holds the transmit queue and the receive queue of a CAN controller and gives the CPU access to both through fixed register windows. Each queue has one window of its own. A window holds a 32-bit identifier word, a 4-bit length code and eight data bytes. The CPU never addresses an individual queue slot. To send a frame, it fills the transmit window and then writes the advance code to the transmit pointer register. That write copies the window into the queue as a new entry. To receive, it reads the receive window, which always shows the oldest stored frame, and then writes the advance code to the receive pointer register, which discards that frame.

On the protocol side, a frame-level handshake stands in for the bus engine. The oldest transmit entry is presented with a valid flag, and a one-cycle done pulse removes it. Received frames arrive with a valid pulse and are stored only while the receive queue is enabled and has room. The CPU sees three kinds of status: the number of unsent frames, a receive-empty flag, and two interrupt status bits that can be masked and that software clears by writing 0.

Top module: `can_fifo_window`

## Requirements
- R1: After reset the following values hold. Transmit control (address 0x8) reads 0: enable is bit 0 and the unsent count is bits 3:1. Receive control (0xA) reads 0x80: empty is bit 7 and enable is bit 0. Interrupt enable (0xC) and interrupt status (0xD) read 0. `irq` and `tx_valid` are low.
- R2: While transmit is enabled, a write to the transmit pointer register (0x9) whose low byte is 0xFF appends the current transmit window to the queue and raises the unsent count by one. The window consists of ID at 0x0, length at 0x1, data bytes 3..0 at 0x2 and data bytes 7..4 at 0x3. A write made while transmit is disabled is ignored. Bits above the low byte are not examined.
- R3: `tx_valid` is high whenever the unsent count is nonzero. The `tx_id`/`tx_dlc`/`tx_data` outputs carry the oldest entry. A `tx_done` pulse while `tx_valid` is high removes that entry, and frames leave in commit order.
- R4: A commit to a full transmit queue (4 entries) is ignored. The count stays at 4.
- R5: While receive is enabled, a `rx_valid` pulse with `rx_ready` high stores the frame. The empty flag clears. The receive window shows the oldest frame: ID at 0x4, length at 0x5, data bytes 3..0 at 0x6 and data bytes 7..4 at 0x7.
- R6: Writing 0xFF to the receive pointer register (0xB) discards the oldest frame. On an empty queue the write is ignored and the queue state does not change.
- R7: A pointer-register write whose low byte is not 0xFF has no effect on either queue.
- R8: Clearing a queue's enable bit flushes it. For transmit, the unsent count becomes 0 and `tx_valid` goes low. For receive, the empty flag sets. While a queue is disabled it accepts no entries, and `rx_ready` is low.
- R9: Interrupt status bit 4 sets when a received frame is stored, and bit 3 sets when a transmit entry is removed. Writing 0 to a status bit clears it and writing 1 leaves it unchanged. `irq` is high exactly when some status bit is set and its enable bit (same position, at 0xC) is set.
- R10: The length window stores only bits 3:0. Bits 31:4 read back as 0. The ID word is stored and forwarded bit-exact, including the format flag in bit 31 and the remote flag in bit 30.
- R11: When the receive queue holds 4 frames, `rx_ready` is low and a further incoming frame is dropped. The stored frames are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 4 | Register word address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data for `cpu_addr` (combinational) |
| irq | output | 1 | Masked FIFO interrupt |
| tx_valid | output | 1 | A transmit entry is pending |
| tx_id | output | 32 | ID word of oldest transmit entry |
| tx_dlc | output | 4 | Length code of oldest transmit entry |
| tx_data | output | 64 | Data of oldest transmit entry, byte 0 in bits 7:0 |
| tx_done | input | 1 | Protocol side has sent the oldest entry |
| rx_valid | input | 1 | Received frame offered |
| rx_id | input | 32 | ID word of offered frame |
| rx_dlc | input | 4 | Length code of offered frame |
| rx_data | input | 64 | Data of offered frame, byte 0 in bits 7:0 |
| rx_ready | output | 1 | Receive queue enabled and not full |

## Verification
The assertions check on every cycle the behaviours that hold cycle by cycle. Queue occupancy never goes past the depth. Pushes to a full queue and pops from an empty one leave the occupancy unchanged. A cleared enable empties its queue. Each event sets its status bit. Status bits change only through an event or a status write. Only the bench scenarios can show the rest: that frames come out in commit order with their contents intact, that the window-to-field mapping is correct, that writes other than 0xFF are ignored, and that a frame dropped on overflow never reappears.

// File: rtl/can_fifo_pkg.sv
// Shared types and register layout for the CAN mailbox FIFO window.
// Assumes a 32-bit word-addressed register port.
package can_fifo_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 4;
    localparam int DLC_W  = 4;

    // One frame as held in a queue slot or a window
    typedef struct packed {
        logic [31:0]      id;
        logic [DLC_W-1:0] dlc;
        logic [63:0]      data;
    } frame_t;

    // Register word addresses
    localparam logic [ADDR_W-1:0] A_TX_ID  = 4'h0;
    localparam logic [ADDR_W-1:0] A_TX_DLC = 4'h1;
    localparam logic [ADDR_W-1:0] A_TX_DLO = 4'h2;
    localparam logic [ADDR_W-1:0] A_TX_DHI = 4'h3;
    localparam logic [ADDR_W-1:0] A_RX_ID  = 4'h4;
    localparam logic [ADDR_W-1:0] A_RX_DLC = 4'h5;
    localparam logic [ADDR_W-1:0] A_RX_DLO = 4'h6;
    localparam logic [ADDR_W-1:0] A_RX_DHI = 4'h7;
    localparam logic [ADDR_W-1:0] A_TX_CTL = 4'h8;
    localparam logic [ADDR_W-1:0] A_TX_PTR = 4'h9;
    localparam logic [ADDR_W-1:0] A_RX_CTL = 4'hA;
    localparam logic [ADDR_W-1:0] A_RX_PTR = 4'hB;
    localparam logic [ADDR_W-1:0] A_IRQ_EN = 4'hC;
    localparam logic [ADDR_W-1:0] A_IRQ_ST = 4'hD;

    // Field positions
    localparam int TX_EN_BIT    = 0;
    localparam int TX_CNT_LSB   = 1;
    localparam int RX_EN_BIT    = 0;
    localparam int RX_EMPTY_BIT = 7;
    localparam int IRQ_TX_BIT   = 3;   // receive bit sits one above
    localparam int IRQ_SRC_N    = 2;

    localparam logic [7:0] PTR_ADVANCE = 8'hFF;
endpackage

// File: rtl/can_frame_fifo.sv
// Circular frame queue with occupancy count and synchronous flush.
// Push on full and pop on empty are dropped. A flush wins over push/pop.
// Storage is not reset; only pointers and count are.
module can_frame_fifo
    import can_fifo_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  frame_t           push_frame,
    input  logic             pop,
    output frame_t           head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    frame_t           mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full && !clear;
    assign pop_ok  = pop && !empty && !clear;
    assign head    = mem[rd_ptr];

    // Store the pushed frame in its slot
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_frame;
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4 R11: occupancy never exceeds the depth
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R4 R11: push into a full queue leaves it full and the write side still
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clear) |=> (full && $stable(wr_ptr)));

    // R6: pop on empty moves nothing
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clear) |=> (empty && $stable(rd_ptr)));

    // R8: flush empties the queue
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty);
endmodule

// File: rtl/can_fifo_irq.sv
// Interrupt status and enable for the queue events.
// Source 0 is transmit-removed (bit IRQ_TX_BIT), source 1 is receive-stored
// (the bit above). An event wins over a clearing write in the same cycle.
module can_fifo_irq
    import can_fifo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IRQ_SRC_N-1:0] evt,
    input  logic                 en_wr,
    input  logic                 st_wr,
    input  logic [7:0]           wbyte,
    output logic [7:0]           en_byte,
    output logic [7:0]           st_byte,
    output logic                 irq
);
    logic [IRQ_SRC_N-1:0] en_q, st_q, st_d;

    // Next status per source: set on event, clear on a written 0
    generate
        for (genvar i = 0; i < IRQ_SRC_N; i++) begin : g_src
            always_comb begin
                if (evt[i])                              st_d[i] = 1'b1;
                else if (st_wr && !wbyte[IRQ_TX_BIT+i])  st_d[i] = 1'b0;
                else                                     st_d[i] = st_q[i];
            end

            // R9: an event always leaves its status bit set
            evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                evt[i] |=> st_byte[IRQ_TX_BIT+i]);
        end
    endgenerate

    // Hold status and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            st_q <= st_d;
            if (en_wr) en_q <= wbyte[IRQ_TX_BIT +: IRQ_SRC_N];
        end
    end

    // Place fields in the register bytes and form the request
    always_comb begin
        en_byte = '0;
        st_byte = '0;
        en_byte[IRQ_TX_BIT +: IRQ_SRC_N] = en_q;
        st_byte[IRQ_TX_BIT +: IRQ_SRC_N] = st_q;
        irq = |(st_q & en_q);
    end

    // R9: without event or status write the status holds
    st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == '0 && !st_wr) |=> $stable(st_byte));
endmodule

// File: rtl/can_fifo_window.sv
// Register front end of the CAN mailbox FIFO window.
// Holds the transmit window, decodes CPU writes into commits and releases,
// and joins two frame queues and the interrupt block. Reads are
// combinational on cpu_addr; writes take effect at the clock edge.
module can_fifo_window
    import can_fifo_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    output logic              irq,
    output logic              tx_valid,
    output logic [31:0]       tx_id,
    output logic [DLC_W-1:0]  tx_dlc,
    output logic [63:0]       tx_data,
    input  logic              tx_done,
    input  logic              rx_valid,
    input  logic [31:0]       rx_id,
    input  logic [DLC_W-1:0]  rx_dlc,
    input  logic [63:0]       rx_data,
    output logic              rx_ready
);
    frame_t           tx_win, tx_head, rx_head, rx_in;
    logic             tx_en, rx_en;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             ptr_code, tx_commit, rx_release, tx_pop, rx_push;
    logic [7:0]       irq_en_byte, irq_st_byte;

    assign ptr_code   = (cpu_wdata[7:0] == PTR_ADVANCE);
    assign tx_commit  = cpu_wr && (cpu_addr == A_TX_PTR) && ptr_code && tx_en;
    assign rx_release = cpu_wr && (cpu_addr == A_RX_PTR) && ptr_code && rx_en;
    assign tx_valid   = !tx_empty;
    assign tx_pop     = tx_done && tx_valid;
    assign rx_ready   = rx_en && !rx_full;
    assign rx_push    = rx_valid && rx_ready;
    assign rx_in      = '{id: rx_id, dlc: rx_dlc, data: rx_data};
    assign tx_id      = tx_head.id;
    assign tx_dlc     = tx_head.dlc;
    assign tx_data    = tx_head.data;

    // CPU writes into the transmit window and the enable bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_win <= '0;
            tx_en  <= 1'b0;
            rx_en  <= 1'b0;
        end else if (cpu_wr) begin
            case (cpu_addr)
                A_TX_ID:  tx_win.id          <= cpu_wdata;
                A_TX_DLC: tx_win.dlc         <= cpu_wdata[DLC_W-1:0];
                A_TX_DLO: tx_win.data[31:0]  <= cpu_wdata;
                A_TX_DHI: tx_win.data[63:32] <= cpu_wdata;
                A_TX_CTL: tx_en              <= cpu_wdata[TX_EN_BIT];
                A_RX_CTL: rx_en              <= cpu_wdata[RX_EN_BIT];
                default:  ;
            endcase
        end
    end

    can_frame_fifo #(.DEPTH(DEPTH)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .clear(!tx_en),
        .push(tx_commit), .push_frame(tx_win), .pop(tx_pop),
        .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    can_frame_fifo #(.DEPTH(DEPTH)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .clear(!rx_en),
        .push(rx_push), .push_frame(rx_in), .pop(rx_release),
        .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    can_fifo_irq u_irq (
        .clk(clk), .rst_n(rst_n), .evt({rx_push, tx_pop}),
        .en_wr(cpu_wr && cpu_addr == A_IRQ_EN),
        .st_wr(cpu_wr && cpu_addr == A_IRQ_ST),
        .wbyte(cpu_wdata[7:0]),
        .en_byte(irq_en_byte), .st_byte(irq_st_byte), .irq(irq)
    );

    // Read multiplexer over windows and control registers
    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            A_TX_ID:  cpu_rdata = tx_win.id;
            A_TX_DLC: cpu_rdata[DLC_W-1:0] = tx_win.dlc;
            A_TX_DLO: cpu_rdata = tx_win.data[31:0];
            A_TX_DHI: cpu_rdata = tx_win.data[63:32];
            A_RX_ID:  cpu_rdata = rx_head.id;
            A_RX_DLC: cpu_rdata[DLC_W-1:0] = rx_head.dlc;
            A_RX_DLO: cpu_rdata = rx_head.data[31:0];
            A_RX_DHI: cpu_rdata = rx_head.data[63:32];
            A_TX_CTL: begin
                cpu_rdata[TX_EN_BIT]            = tx_en;
                cpu_rdata[TX_CNT_LSB +: CNT_W]  = tx_cnt;
            end
            A_RX_CTL: begin
                cpu_rdata[RX_EN_BIT]    = rx_en;
                cpu_rdata[RX_EMPTY_BIT] = rx_empty;
            end
            A_IRQ_EN: cpu_rdata[7:0] = irq_en_byte;
            A_IRQ_ST: cpu_rdata[7:0] = irq_st_byte;
            default:  cpu_rdata = '0;
        endcase
    end

    // R4: a commit on a full transmit queue without a pop keeps the count
    tx_full_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_commit && tx_full && !tx_pop) |=> $stable(tx_cnt));

    // R8: a disabled transmit queue presents nothing
    tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !tx_valid);

    // R11: a refused frame does not change receive occupancy
    rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_en && rx_full && !rx_release) |=> $stable(rx_cnt));
endmodule

// File: tb/tb_can_fifo_window.sv
module tb_can_fifo_window;
    import can_fifo_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        irq, tx_valid, tx_done = 1'b0, rx_valid = 1'b0, rx_ready;
    logic [31:0] tx_id, rx_id = '0;
    logic [3:0]  tx_dlc, rx_dlc = '0;
    logic [63:0] tx_data, rx_data = '0;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    can_fifo_window dut (.*);

    // Row: {op(1=read-compare,0=write), req, addr, data/expected}
    localparam int NV = 19;
    localparam logic [43:0] VEC [NV] = '{
        {4'd0, 4'd2,  4'h8, 32'h0000_0001},   // enable transmit
        {4'd1, 4'd1,  4'h8, 32'h0000_0001},   // R1 count still 0
        {4'd0, 4'd2,  4'h0, 32'h8000_1234},
        {4'd0, 4'd10, 4'h1, 32'h0000_00F8},
        {4'd1, 4'd10, 4'h1, 32'h0000_0008},   // R10 only 3:0 kept
        {4'd0, 4'd2,  4'h2, 32'h1122_3344},
        {4'd0, 4'd2,  4'h3, 32'h5566_7788},
        {4'd1, 4'd10, 4'h0, 32'h8000_1234},   // R10 ID bit-exact
        {4'd0, 4'd2,  4'h9, 32'h0000_00FF},
        {4'd1, 4'd2,  4'h8, 32'h0000_0003},   // R2 count 1
        {4'd0, 4'd7,  4'h9, 32'h0000_007F},
        {4'd1, 4'd7,  4'h8, 32'h0000_0003},   // R7 ignored
        {4'd0, 4'd2,  4'h0, 32'h4C80_0000},
        {4'd0, 4'd2,  4'h1, 32'h0000_0003},
        {4'd0, 4'd2,  4'h9, 32'h0000_01FF},   // only low byte examined
        {4'd1, 4'd2,  4'h8, 32'h0000_0005},   // R2 count 2
        {4'd0, 4'd2,  4'h9, 32'h0000_00FF},
        {4'd0, 4'd2,  4'h9, 32'h0000_00FF},
        {4'd1, 4'd2,  4'h8, 32'h0000_0009}    // R2 count 4
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    task automatic rdchk(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, {32'h0, v}, {32'h0, exp});
    endtask

    task automatic rx_send(input logic [31:0] id, input logic [3:0] dlc, input logic [63:0] dat);
        @(negedge clk);
        rx_valid = 1'b1; rx_id = id; rx_dlc = dlc; rx_data = dat;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic tx_pulse();
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk("R1 tx ctl", 4'h8, 32'h0);
        rdchk("R1 rx ctl", 4'hA, 32'h80);
        rdchk("R1 irq en", 4'hC, 32'h0);
        rdchk("R1 irq st", 4'hD, 32'h0);
        check("R1 irq/tx_valid", {62'h0, irq, tx_valid}, 64'h0);

        // Register vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][43:40] == 4'd0) wr(VEC[i][35:32], VEC[i][31:0]);
            else rdchk($sformatf("R%0d vec%0d", VEC[i][39:36], i), VEC[i][35:32], VEC[i][31:0]);
        end
        // R4 commit on full queue ignored
        wr(4'h9, 32'hFF);
        rdchk("R4 full commit", 4'h8, 32'h9);

        // R3 oldest entry presented, removed in order
        check("R3 valid", {63'h0, tx_valid}, 64'h1);
        check("R3 id", {32'h0, tx_id}, {32'h0, 32'h8000_1234});
        check("R3 dlc", {60'h0, tx_dlc}, 64'h8);
        check("R3 data", tx_data, 64'h5566_7788_1122_3344);
        tx_pulse();
        rdchk("R3 count after pop", 4'h8, 32'h7);
        check("R3 next id", {32'h0, tx_id}, {32'h0, 32'h4C80_0000});
        check("R3 next dlc", {60'h0, tx_dlc}, 64'h3);

        // R9 transmit status and masking
        rdchk("R9 tx status", 4'hD, 32'h08);
        check("R9 masked irq", {63'h0, irq}, 64'h0);
        wr(4'hC, 32'h08);
        check("R9 irq on", {63'h0, irq}, 64'h1);
        wr(4'hD, 32'hFF);
        rdchk("R9 write 1 keeps", 4'hD, 32'h08);
        wr(4'hD, 32'h00);
        rdchk("R9 write 0 clears", 4'hD, 32'h0);
        check("R9 irq off", {63'h0, irq}, 64'h0);

        // R8 transmit flush, commit while disabled ignored
        wr(4'h8, 32'h0);
        rdchk("R8 tx flush", 4'h8, 32'h0);
        check("R8 tx_valid low", {63'h0, tx_valid}, 64'h0);
        wr(4'h9, 32'hFF);
        rdchk("R8 disabled commit", 4'h8, 32'h0);

        // R5 receive path
        wr(4'hA, 32'h1);
        rdchk("R5 rx enabled empty", 4'hA, 32'h81);
        wr(4'hC, 32'h10);
        rx_send(32'h8ABC_DEF0, 4'h5, 64'h0102_0304_0506_0708);
        rx_send(32'h1234_0000, 4'h2, 64'hAA55);
        rdchk("R5 not empty", 4'hA, 32'h01);
        rdchk("R5 rx id", 4'h4, 32'h8ABC_DEF0);
        rdchk("R5 rx dlc", 4'h5, 32'h5);
        rdchk("R5 rx dlo", 4'h6, 32'h0506_0708);
        rdchk("R5 rx dhi", 4'h7, 32'h0102_0304);
        rdchk("R9 rx status", 4'hD, 32'h10);
        check("R9 rx irq", {63'h0, irq}, 64'h1);

        // R7 non-advance code ignored, R6 release
        wr(4'hB, 32'h00);
        rdchk("R7 rx ptr ignored", 4'h4, 32'h8ABC_DEF0);
        wr(4'hB, 32'hFF);
        rdchk("R6 release", 4'h4, 32'h1234_0000);
        wr(4'hB, 32'hFF);
        rdchk("R6 now empty", 4'hA, 32'h81);
        wr(4'hB, 32'hFF);
        rdchk("R6 release on empty", 4'hA, 32'h81);
        rx_send(32'h0000_0C0C, 4'h1, 64'h0);
        rdchk("R6 pointers kept", 4'h4, 32'h0000_0C0C);
        rdchk("R6 one entry", 4'hA, 32'h01);
        wr(4'hB, 32'hFF);

        // R11 overflow drops the fifth frame
        for (int k = 0; k < 4; k++) rx_send(32'h100 + k, 4'h0, 64'h0);
        check("R11 ready low", {63'h0, rx_ready}, 64'h0);
        rx_send(32'h1FF, 4'h0, 64'h0);
        for (int k = 0; k < 4; k++) begin
            rdchk("R11 kept order", 4'h4, 32'h100 + k);
            wr(4'hB, 32'hFF);
        end
        rdchk("R11 fifth dropped", 4'hA, 32'h81);

        // R8 receive flush
        rx_send(32'h7, 4'h0, 64'h0);
        rx_send(32'h8, 4'h0, 64'h0);
        wr(4'hA, 32'h0);
        rdchk("R8 rx flush", 4'hA, 32'h80);
        check("R8 rx_ready low", {63'h0, rx_ready}, 64'h0);
        rx_send(32'h9, 4'h0, 64'h0);
        wr(4'hA, 32'h1);
        rdchk("R8 still empty", 4'hA, 32'h81);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule